// File: doc/BRIEF.md
# Prescaled Down-Counter Timer with Compare Flag

This block is a memory-mapped interval timer. A 32-bit counter counts down by one on each prescaled tick. One of three tick-enable inputs is chosen as the clock source, or none at all. A 12-bit divider then thins that source out. When the counter reaches zero it either reloads from a software-written load value or wraps to all-ones and keeps counting.

A compare register is checked on every decrement. When the counter lands on the compare value, a sticky status flag is set. That flag drives the interrupt line when interrupts and the timer are both enabled.

Software reaches the block through a single-cycle synchronous port. Each write takes effect on the clock edge where `we_i` is high. Reads are combinational from `addr_i`. A software-reset control bit returns the registers to their defaults but keeps a chosen set of mode bits. An overwrite option lets a load write go straight into the running counter.

Top module: `periodic_cmp_timer`

## Requirements
- R1: Word address 0 reads control, 1 reads status (flag in bit 0), 2 reads load, 3 reads compare and 4 reads the counter. Address 4 ignores writes. Addresses 5 to 7 read zero and ignore writes. After hardware reset, load reads 0xFFFFFFFF and every other register reads zero.
- R2: Control stores only bits 25:0 of a write, so bits 31:26 read zero. Control bit positions are:
  - enable 0, reload-start 1, compare-irq-enable 2, reload-mode 3
  - divider 15:4, soft-reset 16, overwrite 17
  - held mode bits 21:18, source 25:24
  The soft-reset bit always reads zero.
- R3: Source 0 selects no tick, so the counter never decrements. Sources 1, 2 and 3 select `tick_i[0]`, `tick_i[1]` and `tick_i[2]`.
- R4: While enabled, the counter decrements once per P+1 selected ticks, where P is the divider field. The divider phase restarts on an enable rising edge and on soft reset.
- R5: A decrement from zero loads the load value when reload-mode is 1. When reload-mode is 0, it loads 0xFFFFFFFF.
- R6: A control write that takes enable from 0 to 1 with reload-start set loads the counter. It loads the load value if reload-mode is set, otherwise 0xFFFFFFFF. With reload-start clear, counting resumes from the held value.
- R7: While enable is 0, the counter and the divider phase hold their values.
- R8: A load write while the overwrite bit is set places the written value in the counter on the same edge. This takes priority over a decrement in that cycle, and that decrement cannot set the flag.
- R9: The flag is set when a decrement makes the counter equal to compare. Once set, it stays set until it is cleared. A set and a status clear in the same cycle leave the flag set.
- R10: A status write with bit 0 high clears the flag. A status write with bit 0 low changes nothing.
- R11: `irq_o` is high exactly when the flag, enable and compare-irq-enable are all set.
- R12: A control write with soft-reset set does the following:
  - keeps only bits 0, 1 and 21:18 of the written value;
  - clears the flag and compare;
  - sets load to 0xFFFFFFFF;
  - zeroes the counter, unless the same write is an R6 loading enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tick_i | input | 3 | Tick-enable inputs, one per source |
| irq_o | output | 1 | Compare interrupt |

## Verification
A compare hit is the result of a decrement, and it can fall in the same cycle as a software status clear. It can also coincide with a load write that overwrites the counter. The bench sets compare to a value the counter is about to reach. It then issues the status clear, or the overwriting load, on exactly the edge where that value arrives. It checks that the flag survives the clear and that the overwrite wins over the decrement without raising the flag. Constrained random traffic with small load and compare values keeps producing these collisions, and a requirement-level model judges every read and the interrupt level.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int CTRL_W   = 26;
  localparam int B_EN     = 0;
  localparam int B_ENMOD  = 1;
  localparam int B_CIE    = 2;
  localparam int B_RLD    = 3;
  localparam int B_DIV_LO = 4;
  localparam int DIV_W    = 12;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_SRC_LO = 24;
  localparam int SRC_W    = 2;
  // enable, reload-start and the four held mode bits survive soft reset
  localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h03C_0003;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_LOAD = 3'd2,
    A_CMP  = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ptm_tick_gen.sv
module ptm_tick_gen #(
  parameter int NSRC = 3,
  parameter int SW   = 2,
  parameter int PW   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [SW-1:0]   src_i,
  input  logic [PW-1:0]   div_i,
  input  logic [NSRC-1:0] tick_i,
  output logic            dec_o
);
  localparam int NSEL = 1 << SW;

  logic [NSEL-1:0] sel_vec;
  logic [PW-1:0]   pre_q;
  logic            sel, wrap;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    if (g == 0) begin : g_none
      assign sel_vec[g] = 1'b0;
    end else if (g <= NSRC) begin : g_src
      assign sel_vec[g] = tick_i[g-1];
    end else begin : g_pad
      assign sel_vec[g] = 1'b0;
    end
  end

  assign sel  = sel_vec[src_i];
  // >= keeps a shrunken divider from stalling for a full phase wrap
  assign wrap = pre_q >= div_i;
  assign dec_o = run_i & sel & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (run_i && sel)   pre_q <= wrap ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          rld_i,
  input  logic [CW-1:0] load_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          force_i,
  input  logic [CW-1:0] force_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q, nxt;

  assign nxt   = (cnt_q == '0) ? (rld_i ? load_i : '1) : cnt_q - 1'b1;
  assign hit_o = dec_i & ~force_i & (nxt == cmp_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (force_i) cnt_q <= force_val_i;
    else if (dec_i)   cnt_q <= nxt;
  end
endmodule

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              hit_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              flag_o,
  output logic [CW-1:0]     load_o,
  output logic [CW-1:0]     cmp_o,
  output logic              swr_o,
  output logic              en_rise_o,
  output logic              force_o,
  output logic [CW-1:0]     force_val_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d, wv;
  logic              flag_q;
  logic [CW-1:0]     load_q, cmp_q;
  logic              ctrl_wr, stat_wr, load_wr, cmp_wr, ovw_wr, start_ld;

  assign ctrl_wr = we_i && (addr_i == A_CTRL);
  assign stat_wr = we_i && (addr_i == A_STAT);
  assign load_wr = we_i && (addr_i == A_LOAD);
  assign cmp_wr  = we_i && (addr_i == A_CMP);

  assign wv        = wdata_i[CTRL_W-1:0];
  assign swr_o     = ctrl_wr & wv[B_SWR];
  assign ctrl_d    = swr_o ? (wv & KEEP_MASK) : wv;
  assign en_rise_o = ctrl_wr & ~ctrl_q[B_EN] & ctrl_d[B_EN];
  assign ovw_wr    = load_wr & ctrl_q[B_OVW];
  assign start_ld  = en_rise_o & ctrl_d[B_ENMOD];

  // priority: overwrite, enable-edge load, soft-reset clear
  always_comb begin
    force_o     = ovw_wr | start_ld | swr_o;
    force_val_o = '0;
    if (ovw_wr)
      force_val_o = wdata_i[CW-1:0];
    else if (start_ld)
      force_val_o = (ctrl_d[B_RLD] && !swr_o) ? load_q : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      load_q <= '1;
      cmp_q  <= '0;
    end else if (swr_o) begin
      ctrl_q <= ctrl_d;
      flag_q <= 1'b0;
      load_q <= '1;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (load_wr) load_q <= wdata_i[CW-1:0];
      if (cmp_wr)  cmp_q  <= wdata_i[CW-1:0];
      if (hit_i)                      flag_q <= 1'b1;
      else if (stat_wr && wdata_i[0]) flag_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/periodic_cmp_timer.sv
module periodic_cmp_timer
  import ptm_pkg::*;
#(
  parameter int CW   = 32,
  parameter int NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [NSRC-1:0] tick_i,
  output logic            irq_o
);
  logic [CTRL_W-1:0] ctrl;
  logic              flag, swr, en_rise, force_ld, dec, hit;
  logic [CW-1:0]     load, cmp, cnt, force_val;

  ptm_regs #(.CW(CW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .hit_i(hit), .ctrl_o(ctrl), .flag_o(flag),
    .load_o(load), .cmp_o(cmp), .swr_o(swr), .en_rise_o(en_rise),
    .force_o(force_ld), .force_val_o(force_val)
  );

  ptm_tick_gen #(.NSRC(NSRC), .SW(SRC_W), .PW(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl[B_EN]),
    .clr_i(swr | en_rise),
    .src_i(ctrl[B_SRC_LO +: SRC_W]), .div_i(ctrl[B_DIV_LO +: DIV_W]),
    .tick_i(tick_i), .dec_o(dec)
  );

  ptm_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec), .rld_i(ctrl[B_RLD]),
    .load_i(load), .cmp_i(cmp), .force_i(force_ld),
    .force_val_i(force_val), .cnt_o(cnt), .hit_o(hit)
  );

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = 32'(ctrl);
      A_STAT:  rdata_o = {31'b0, flag};
      A_LOAD:  rdata_o = 32'(load);
      A_CMP:   rdata_o = 32'(cmp);
      A_CNT:   rdata_o = 32'(cnt);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctrl[B_EN] & ctrl[B_CIE];
endmodule

// File: rtl/ptm_chk.sv
module ptm_chk
  import ptm_pkg::*;
#(
  parameter int CW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [CTRL_W-1:0] ctrl,
  input logic              flag,
  input logic              dec,
  input logic [CW-1:0]     cnt
);
  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> (rdata_o[31:26] == 6'b0 && !rdata_o[B_SWR]));

  // R3
  no_source_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[B_SRC_LO +: SRC_W] == '0 && !we_i) |=> $stable(cnt));

  // R7
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[B_EN] && !we_i) |=> $stable(cnt));

  // R5
  free_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && cnt == '0 && !ctrl[B_RLD] && !we_i) |=> (cnt == {CW{1'b1}}));

  // R8
  overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_LOAD && ctrl[B_OVW]) |=> (cnt == $past(wdata_i[CW-1:0])));

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !(we_i && addr_i == A_STAT && wdata_i[0])
          && !(we_i && addr_i == A_CTRL && wdata_i[B_SWR])) |=> flag);

  // R11
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag && ctrl[B_EN] && ctrl[B_CIE]));
endmodule

bind periodic_cmp_timer ptm_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .ctrl(ctrl),
  .flag(flag), .dec(dec), .cnt(cnt)
);

// File: tb/tb_periodic_cmp_timer.sv
`timescale 1ns/1ps
module tb_periodic_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  tick = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  logic [25:0] m_ctrl;
  logic        m_flag;
  logic [31:0] m_load, m_cmp, m_cnt;
  logic [11:0] m_pre;
  logic [25:0] n_ctrl;
  logic        n_flag;
  logic [31:0] n_load, n_cmp, n_cnt;
  logic [11:0] n_pre;

  always #5 clk = ~clk;

  periodic_cmp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {6'b0, m_ctrl};
      3'd1: return {31'b0, m_flag};
      3'd2: return m_load;
      3'd3: return m_cmp;
      3'd4: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int src, input int dv, input logic [31:0] bits);
    return bits | (32'(src) << 24) | (32'(dv) << 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic [2:0] a, input logic [31:0] d,
                            input logic [2:0] t);
    logic en, sel, dec, hit, ovw;
    logic [1:0] src;
    logic [31:0] nc;
    logic [25:0] v;
    en = m_ctrl[0]; src = m_ctrl[25:24];
    sel = (src == 2'd0) ? 1'b0 : t[src-1];
    n_ctrl = m_ctrl; n_flag = m_flag; n_load = m_load;
    n_cmp = m_cmp; n_cnt = m_cnt; n_pre = m_pre;
    dec = 1'b0; hit = 1'b0; nc = '0;
    if (en && sel) begin
      if (m_pre >= m_ctrl[15:4]) begin n_pre = '0; dec = 1'b1; end
      else n_pre = m_pre + 1'b1;
    end
    ovw = w && a == 3'd2 && m_ctrl[17];
    if (dec) begin
      nc = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
      if (!ovw) begin
        n_cnt = nc;
        if (nc == m_cmp) begin n_flag = 1'b1; hit = 1'b1; end
      end
    end
    if (w) begin
      case (a)
        3'd0: begin
          v = d[25:0];
          if (v[16]) begin
            n_ctrl = v & 26'h03C_0003; n_flag = 1'b0; n_load = 32'hFFFF_FFFF;
            n_cmp = '0; n_cnt = '0; n_pre = '0;
          end else n_ctrl = v;
          if (!en && n_ctrl[0]) begin
            n_pre = '0;
            if (n_ctrl[1]) n_cnt = n_ctrl[3] ? n_load : 32'hFFFF_FFFF;
          end
        end
        3'd1: if (d[0] && !hit) n_flag = 1'b0;
        3'd2: begin n_load = d; if (ovw) n_cnt = d; end
        3'd3: n_cmp = d;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                     input logic [2:0] t);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t;
    model_step(w, a, d, t);
    @(posedge clk);
    #1;
    m_ctrl = n_ctrl; m_flag = n_flag; m_load = n_load;
    m_cmp = n_cmp; m_cnt = n_cnt; m_pre = n_pre;
    we = 1'b0; tick = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    we = 1'b0; addr = a;
    #1;
    chk(tag, rdata, m_read(a));
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {31'b0, irq}, {31'b0, m_flag & m_ctrl[0] & m_ctrl[2]});
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    m_ctrl = '0; m_flag = 1'b0; m_load = 32'hFFFF_FFFF;
    m_cmp = '0; m_cnt = '0; m_pre = '0;
    #23 rst_n = 1'b1;
    #1;
    // R1 reset state and map
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset");
    addr = 3'd2; #1; chk("R1 reset load", rdata, 32'hFFFF_FFFF);

    // R2 masking, soft-reset bit not set
    cyc(1, 0, 32'hFFFE_FFFE, 0);
    addr = 3'd0; #1; chk("R2 ctrl mask", rdata, 32'h03FE_FFFE);
    cyc(1, 0, 0, 0);
    // R1 count read-only, holes ignore writes
    cyc(1, 4, 32'h1234_5678, 0);
    cyc(1, 5, 32'hFFFF_FFFF, 0);
    cyc(1, 7, 32'hFFFF_FFFF, 0);
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 ignored writes");

    // R3 no source
    cyc(1, 0, mk(0, 0, 32'h3), 0);
    addr = 3'd4; #1; chk("R6 start load", rdata, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 3'b111);
    addr = 3'd4; #1; chk("R3 no source", rdata, 32'hFFFF_FFFF);
    // R3 source 2 ignores tick 0, follows tick 1
    cyc(1, 0, mk(2, 0, 32'h1), 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 3'b101);
    rd(4, "R3 wrong tick");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 3'b010);
    addr = 3'd4; #1; chk("R3 selected tick", rdata, 32'hFFFF_FFFC);

    // R4 divider P=3
    cyc(1, 0, 0, 0);
    cyc(1, 0, mk(3, 3, 32'h3), 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 3'b100);
    addr = 3'd4; #1; chk("R4 before divide", rdata, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 3'b100);
    addr = 3'd4; #1; chk("R4 divide", rdata, 32'hFFFF_FFFE);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 3'b100);
    rd(4, "R4 divide run");

    // R5 reload mode, R9 compare, R11 irq
    cyc(1, 0, 0, 0);
    cyc(1, 2, 32'd5, 0);
    cyc(1, 3, 32'd2, 0);
    cyc(1, 0, mk(1, 0, 32'hF), 0);
    rd(4, "R6 reload start");
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 3'b001);
      rd(4, "R5 reload count");
      rd(1, "R9 flag");
      chk_irq("R11 irq");
    end
    cyc(1, 1, 32'h0, 0);
    rd(1, "R10 write zero");
    cyc(1, 1, 32'h1, 0);
    rd(1, "R10 clear");
    chk_irq("R11 irq low");

    // R9 clear colliding with hit: count now known; target next value
    cyc(1, 3, m_cnt - 1, 0);
    cyc(1, 1, 32'h1, 3'b001);
    addr = 3'd1; #1; chk("R9 set beats clear", rdata, 32'h1);
    chk_irq("R11 collision");

    // R8 overwrite in free mode, and collision with decrement
    cyc(1, 0, 0, 0);
    cyc(1, 1, 32'h1, 0);
    cyc(1, 0, mk(1, 0, 32'h20007), 0);
    cyc(1, 3, 32'd9, 0);
    cyc(1, 2, 32'd10, 3'b001);
    addr = 3'd4; #1; chk("R8 overwrite beats dec", rdata, 32'd10);
    rd(1, "R8 no flag");
    cyc(1, 2, 32'd1, 0);
    addr = 3'd4; #1; chk("R8 overwrite", rdata, 32'd1);
    cyc(0, 0, 0, 3'b001);
    cyc(0, 0, 0, 3'b001);
    addr = 3'd4; #1; chk("R5 free wrap", rdata, 32'hFFFF_FFFF);

    // R7 freeze and R6 resume
    cyc(1, 0, mk(1, 0, 32'h20006), 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 3'b001);
    addr = 3'd4; #1; chk("R7 frozen", rdata, 32'hFFFF_FFFF);
    cyc(1, 0, mk(1, 0, 32'h20005), 0);
    cyc(0, 0, 0, 3'b001);
    addr = 3'd4; #1; chk("R6 resume", rdata, 32'hFFFF_FFFE);

    // R12 soft reset
    cyc(1, 3, 32'd77, 0);
    cyc(1, 2, 32'd3, 0);
    cyc(1, 0, 32'hFFFF_FFF8 | 32'h1, 0);
    addr = 3'd0; #1; chk("R12 kept bits", rdata, 32'h003C_0001);
    for (int a = 0; a < 5; a++) rd(3'(a), "R12 defaults");

    // random traffic
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 16;
      d = $urandom;
      case (op)
        0, 1: begin
          d[15:4] = 12'($urandom % 3);
          d[16] = ($urandom % 16 == 0);
          cyc(1, 0, d, 3'($urandom));
        end
        2: cyc(1, 1, d, 3'($urandom));
        3: cyc(1, 2, ($urandom % 4 == 0) ? d : 32'($urandom % 12), 3'($urandom));
        4: cyc(1, 3, 32'($urandom % 12), 3'($urandom));
        5: cyc(1, 3'(4 + $urandom % 4), d, 3'($urandom));
        default: cyc(0, 0, 0, 3'($urandom));
      endcase
      rd(3'($urandom % 8), "R1 random read");
      rd(4, "R5 random count");
      chk_irq("R11 random irq");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule